// File: doc/BRIEF.md
# Overflow Event Timer

This block is a 32-bit up-counting timer behind a small register port. Software picks a delay by writing the all-ones value minus the wanted cycle count into the counter and then setting the run bit. The timer raises its event when the count rolls over past all-ones. The event sets a sticky flag, and the flag drives an interrupt line while the interrupt enable is set.

A separate reload register sets the behaviour after an overflow. With the reload bit set, every overflow copies the reload value into the counter and counting goes on, which gives a periodic event. With a reload value of zero the counter becomes a continuous free-running cycle counter that software can read at any time. With the reload bit clear, the timer stops at the overflow, which gives a one-shot event.

Top module: `ovf_timer`

## Requirements
- R1: After reset, the count, the reload value, the control bits, the overflow flag, the interrupt enable and `irq_o` are all zero.
- R2: While the run bit is 1, the count goes up by exactly one on every clock. A count read returns the value held at the clock edge that accepts the read.
- R3: An overflow is a running count of all-ones meeting a clock edge. When the reload bit is 1, that edge loads the reload value into the counter and counting continues.
- R4: When the reload bit is 0, the overflow edge clears the run bit and the count becomes 0 and stays 0.
- R5: Writing 0 to the run bit freezes the count, and later reads return the frozen value.
- R6: With the count written as 0xFFFFFFFF minus N and the run bit then set, the overflow flag and `irq_o` (enable set) become 1 on the (N+1)th rising edge after the edge that accepts the run write.
- R7: The overflow flag is sticky. Writing 1 to status bit 0 clears it and writing 0 leaves it alone. A flag set and a clear on the same edge leave the flag at 1.
- R8: `irq_o` is a register that equals the overflow flag AND the enable bit. It stays high until the flag is cleared or the enable bit is cleared.
- R9: Writing the reload register never changes the count.
- R10: With a reload value of 0 and the reload bit set, the count wraps from all-ones to 0 and keeps running as a free cycle counter.
- R11: Register map, word addresses: 0 = control (bit 0 run, bit 1 reload, other bits read 0); 1 = count; 2 = reload value; 3 = status (bit 0 overflow flag); 4 = interrupt enable (bit 0). Read data appears with `rd_valid_o` one clock after the request. Unmapped addresses read 0.
- R12: A software write to the count on the overflow edge takes priority over the reload or the clear. The control bits still follow R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DW | Read data |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The hardest cases to reach from the ports are collisions on the overflow edge itself: a software count write or a status clear landing on the very cycle the counter rolls over. The stimulus loads the count two steps below all-ones and starts it. It then counts bus cycles so that the colliding write is accepted on exactly the second edge after the start. It then reads the count, control and status back to see which action won.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  localparam int ADR_CTRL  = 0;
  localparam int ADR_COUNT = 1;
  localparam int ADR_LOAD  = 2;
  localparam int ADR_STAT  = 3;
  localparam int ADR_IEN   = 4;

  typedef struct packed {
    logic ctrl;
    logic count;
    logic load;
    logic stat;
    logic ien;
  } wr_strobe_t;
endpackage

// File: rtl/ovf_timer_regs.sv
module ovf_timer_regs
  import ovf_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [DW-1:0]     cnt_i,
  input  logic              run_i,
  input  logic              reload_i,
  input  logic              flag_i,
  input  logic              ien_i,
  output wr_strobe_t        wr_o,
  output logic [DW-1:0]     load_o,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o
);
  logic wr_en, rd_en;
  logic [DW-1:0] rd_mux;

  assign wr_en = req_valid_i && req_write_i;
  assign rd_en = req_valid_i && !req_write_i;

  always_comb begin
    wr_o.ctrl  = wr_en && (req_addr_i == AW'(ADR_CTRL));
    wr_o.count = wr_en && (req_addr_i == AW'(ADR_COUNT));
    wr_o.load  = wr_en && (req_addr_i == AW'(ADR_LOAD));
    wr_o.stat  = wr_en && (req_addr_i == AW'(ADR_STAT));
    wr_o.ien   = wr_en && (req_addr_i == AW'(ADR_IEN));
  end

  always_ff @(posedge clk) begin
    if (rst) load_o <= '0;
    else if (wr_o.load) load_o <= req_wdata_i;
  end

  always_comb begin
    rd_mux = '0;
    case (req_addr_i)
      AW'(ADR_CTRL):  rd_mux = {{(DW-2){1'b0}}, reload_i, run_i};
      AW'(ADR_COUNT): rd_mux = cnt_i;
      AW'(ADR_LOAD):  rd_mux = load_o;
      AW'(ADR_STAT):  rd_mux = {{(DW-1){1'b0}}, flag_i};
      AW'(ADR_IEN):   rd_mux = {{(DW-1){1'b0}}, ien_i};
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en;
      if (rd_en) rd_data_o <= rd_mux;
    end
  end
endmodule

// File: rtl/ovf_timer_core.sv
module ovf_timer_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl_i,
  input  logic          wr_count_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] load_i,
  output logic [DW-1:0] cnt_o,
  output logic          run_o,
  output logic          reload_o,
  output logic          ovf_o
);
  localparam logic [DW-1:0] CNT_MAX = '1;

  assign ovf_o = run_o && (cnt_o == CNT_MAX);

  // count: software write wins, then overflow, then increment
  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else if (wr_count_i) cnt_o <= wdata_i;
    else if (ovf_o) cnt_o <= reload_o ? load_i : '0;
    else if (run_o) cnt_o <= cnt_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o    <= 1'b0;
      reload_o <= 1'b0;
    end else if (wr_ctrl_i) begin
      run_o    <= wdata_i[0];
      reload_o <= wdata_i[1];
    end else if (ovf_o && !reload_o) begin
      run_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ovf_timer_irq.sv
module ovf_timer_irq (
  input  logic clk,
  input  logic rst,
  input  logic ovf_i,
  input  logic clr_i,
  input  logic wr_ien_i,
  input  logic ien_bit_i,
  output logic flag_o,
  output logic ien_o,
  output logic irq_o
);
  logic flag_d, ien_d;

  assign flag_d = ovf_i || (flag_o && !clr_i);
  assign ien_d  = wr_ien_i ? ien_bit_i : ien_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      ien_o  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_d;
      ien_o  <= ien_d;
      irq_o  <= flag_d && ien_d;
    end
  end
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  wr_strobe_t    wr;
  logic [DW-1:0] load_q, cnt_q;
  logic          run_q, reload_q, ovf, flag_q, ien_q;

  ovf_timer_regs #(.DW(DW), .AW(AW)) regs_i (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .cnt_i(cnt_q), .run_i(run_q), .reload_i(reload_q),
    .flag_i(flag_q), .ien_i(ien_q),
    .wr_o(wr), .load_o(load_q),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  ovf_timer_core #(.DW(DW)) core_i (
    .clk(clk), .rst(rst),
    .wr_ctrl_i(wr.ctrl), .wr_count_i(wr.count),
    .wdata_i(req_wdata_i), .load_i(load_q),
    .cnt_o(cnt_q), .run_o(run_q), .reload_o(reload_q), .ovf_o(ovf)
  );

  ovf_timer_irq irq_i (
    .clk(clk), .rst(rst),
    .ovf_i(ovf), .clr_i(wr.stat && req_wdata_i[0]),
    .wr_ien_i(wr.ien), .ien_bit_i(req_wdata_i[0]),
    .flag_o(flag_q), .ien_o(ien_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ovf,
  input logic [DW-1:0] cnt,
  input logic          run,
  input logic          reload,
  input logic [DW-1:0] load,
  input logic          wr_count,
  input logic          wr_ctrl,
  input logic          flag,
  input logic          ien,
  input logic          irq
);
  a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
    run && !wr_count && !ovf |=> cnt == DW'($past(cnt) + 1'b1));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !run && !wr_count |=> $stable(cnt));

  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    ovf && reload && !wr_count |=> cnt == $past(load));

  a_r4_oneshot: assert property (@(posedge clk) disable iff (rst)
    ovf && !reload && !wr_ctrl && !wr_count |=> !run && cnt == '0);

  a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
    ovf |=> flag);

  a_r8_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> flag && ien);
endmodule

bind ovf_timer ovf_timer_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .ovf(ovf), .cnt(cnt_q), .run(run_q),
  .reload(reload_q), .load(load_q), .wr_count(wr.count),
  .wr_ctrl(wr.ctrl), .flag(flag_q), .ien(ien_q), .irq(irq_o)
);

// File: tb/ovf_timer_tb_top.sv
module ovf_timer_tb_top;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  ovf_timer #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input int a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk_irq(input logic exp, input string req);
    check(irq === exp, req, {31'b0, irq}, {31'b0, exp});
  endtask

  // monitor: pop expected read data as results come out
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected read", rd_data, '0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", '0, '0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state, R11 map
    chk_irq(1'b0, "R1 irq");
    bus_rd(0, 0, "R1 ctrl");
    bus_rd(1, 0, "R1 count");
    bus_rd(2, 0, "R1 load");
    bus_rd(3, 0, "R1 status");
    bus_rd(4, 0, "R1 enable");
    bus_rd(7, 0, "R11 unmapped");

    // R2 increment, R5 freeze
    bus_wr(1, 100);
    bus_wr(0, 1);
    idle(5);
    bus_wr(0, 0);
    bus_rd(1, 106, "R2 count");
    idle(3);
    bus_rd(1, 106, "R5 frozen");
    bus_rd(0, 0, "R5 ctrl");

    // R9 load write leaves count
    bus_wr(2, 32'h1234);
    bus_rd(1, 106, "R9 count");
    bus_rd(2, 32'h1234, "R9 load");

    // R6 delay of N=5, R4 one-shot
    bus_wr(4, 1);
    bus_wr(1, 32'hFFFF_FFFA);
    bus_wr(0, 1);
    idle(5); #1;
    chk_irq(1'b0, "R6 before");
    @(posedge clk); #1;
    chk_irq(1'b1, "R6 at N+1");
    bus_rd(3, 1, "R6 flag");
    bus_rd(0, 0, "R4 run cleared");
    bus_rd(1, 0, "R4 count zero");
    idle(3);
    bus_rd(1, 0, "R4 holds");

    // R7 sticky flag, R8 gating
    bus_wr(3, 0);
    bus_rd(3, 1, "R7 write0");
    chk_irq(1'b1, "R8 held");
    bus_wr(4, 0);
    chk_irq(1'b0, "R8 disabled");
    bus_wr(4, 1);
    chk_irq(1'b1, "R8 enabled");
    bus_wr(3, 1);
    chk_irq(1'b0, "R7 cleared irq");
    bus_rd(3, 0, "R7 cleared");

    // R3 periodic reload
    bus_wr(2, 32'hFFFF_FFF0);
    bus_wr(1, 32'hFFFF_FFFE);
    bus_wr(0, 3);
    idle(4);
    bus_wr(0, 2);
    bus_rd(1, 32'hFFFF_FFF3, "R3 count");
    bus_rd(0, 2, "R3 ctrl");
    bus_rd(3, 1, "R3 flag");
    bus_wr(3, 1);

    // R10 free-running wrap
    bus_wr(2, 0);
    bus_wr(1, 32'hFFFF_FFFF);
    bus_wr(0, 3);
    idle(2);
    bus_wr(0, 2);
    bus_rd(1, 2, "R10 count");
    bus_wr(3, 1);

    // R12 count write on the overflow edge
    bus_wr(1, 32'hFFFF_FFFE);
    bus_wr(0, 1);
    idle(1);
    bus_wr(1, 5);
    bus_rd(1, 5, "R12 count");
    bus_rd(0, 0, "R12 ctrl");
    bus_rd(3, 1, "R12 flag");
    bus_wr(3, 1);

    // R7 set beats clear on the same edge
    bus_wr(1, 32'hFFFF_FFFE);
    bus_wr(0, 1);
    idle(1);
    bus_wr(3, 1);
    bus_rd(3, 1, "R7 set wins");

    idle(3);
    check(exp_q.size() == 0, "R11 reads done", DW'(exp_q.size()), '0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule